// File: doc/BRIEF.md
# Serial TDM Frame Receiver

This block is the receive half of a controller's link to an audio codec. It runs on the codec's bit clock and samples the serial data line on every falling edge. It uses the frame sync pulse that the controller drives to find where each 256-bit frame starts. Every frame has a 16-bit tag followed by twelve 20-bit slots. The receiver gathers a whole frame and then publishes all of it at once: the twelve slot words side by side, one valid flag per slot taken from the tag, the flag that says the codec is ready, and the interrupt bit carried in the last position of the frame.

Once a frame is complete, a one-cycle strobe marks the moment the published values change. If a sync edge arrives before the frame is full, the block reports a framing error, throws the partial frame away and starts counting again from the new sync. If the sync edge is missing at the end of a frame, the bit counter keeps running on its own, so frames are still delivered on a 256-bit rhythm.

Top module: `tdm_frame_rx`

## Requirements
- R1: A synchronous active-high reset, sampled on a falling bit-clock edge, sets every output to zero and clears the lock. After reset nothing is published until a sync rising edge has been seen and a full frame has followed it.
- R2: Data and sync are sampled on falling edges of the bit clock. The sample taken at the edge where sync is first seen high (after being low) is the last bit of the frame then in progress. The sample at the next falling edge is F0. Bits that arrive before the first sync edge are dropped.
- R3: `codec_ready` equals bit F0 of the most recently published frame.
- R4: `slot_valid` bit i (i = 0..11) equals frame bit F(i+1). So bit 0 is the flag for slot 1 and bit 11 is the flag for slot 12. Tag bits F13 to F15 have no effect on any output.
- R5: Slot k (k = 1..12) appears on `slot_data[(k-1)*20 +: 20]`. Its most significant bit D19 is frame bit F(16+20(k-1)) and its D0 is F(35+20(k-1)).
- R6: `gpio_irq` equals frame bit F255 (D0 of slot 12) of the most recently published frame, whatever the value of the slot 12 valid flag.
- R7: `frame_stb` is high for exactly one bit-clock cycle, starting at the falling edge that captured F255. `slot_data`, `slot_valid`, `codec_ready` and `gpio_irq` change only at that same edge, and all of them change together.
- R8: A sync rising edge seen while locked at any position other than F255 makes `frame_err` high for one cycle. The partial frame is discarded: there is no strobe and the outputs keep their values. The next sample is taken as F0.
- R9: If no sync edge coincides with F255, the sample that follows F255 is F0 of the next frame and frames continue to be published. A later sync edge at some other position is handled as in R8.
- R10: A sync level that stays high for many bits counts only once. Only a low-to-high transition restarts the frame and none of the later high samples does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all state updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync; a rising edge marks the last bit of the current frame |
| sdata | input | 1 | Serial data from the codec, launched on the rising edge |
| slot_data | output | NUM_SLOTS*SLOT_BITS | Slot words of the last complete frame, slot 1 in the low bits |
| slot_valid | output | NUM_SLOTS | Per-slot valid flags from the tag, bit 0 for slot 1 |
| codec_ready | output | 1 | Codec-ready flag of the last complete frame |
| gpio_irq | output | 1 | Interrupt bit carried in the final frame position |
| frame_stb | output | 1 | One-cycle pulse when the outputs take a new frame |
| frame_err | output | 1 | One-cycle pulse on a sync edge at the wrong bit position |

## Verification
The cases that are hardest to reach from the ports are the ones where sync and the bit counter disagree. These are an early sync that cuts a frame short, a sync that never comes so the counter has to run on its own and is then hit by a late edge, a sync held high far longer than the tag, and a reset in the middle of a frame. The stimulus task builds each frame bit by bit and takes three controls: the frame length, how long sync stays high at the start, and whether sync rises on the final bit. Chaining calls to it produces each of these misalignments on purpose. After every such event a full frame is sent, and its fields are checked straight against the bits that were driven.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  // Default frame geometry: one tag word followed by equal-width slots.
  localparam int unsigned TAG_W_DEF   = 16;
  localparam int unsigned SLOT_W_DEF  = 20;
  localparam int unsigned N_SLOTS_DEF = 12;

  function automatic int unsigned frame_len(input int unsigned tag_w,
                                            input int unsigned slot_w,
                                            input int unsigned n_slots);
    return tag_w + slot_w * n_slots;
  endfunction

endpackage

// File: rtl/tdm_rx_framer.sv
// Tracks the bit position inside the frame from the sync line.
module tdm_rx_framer #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic sync,
  output logic last_bit,
  output logic frame_err
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic             sync_q;
  logic             locked;
  logic [CNT_W-1:0] pos;
  logic             sync_rise;
  logic             at_end;

  assign sync_rise = sync & ~sync_q;
  assign at_end    = (pos == LAST_POS);
  assign last_bit  = locked & at_end;

  always_ff @(negedge clk) begin
    if (rst) begin
      sync_q    <= 1'b0;
      locked    <= 1'b0;
      pos       <= '0;
      frame_err <= 1'b0;
    end else begin
      sync_q    <= sync;
      frame_err <= locked & sync_rise & ~at_end;
      if (sync_rise) begin
        pos    <= '0;
        locked <= 1'b1;
      end else if (locked) begin
        pos <= at_end ? '0 : pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_rx_deser.sv
// Serial-to-parallel history of the last FRAME_BITS samples, oldest in the MSB.
module tdm_rx_deser #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  sdata,
  output logic [FRAME_BITS-1:0] frame
);

  logic [FRAME_BITS-2:0] hist;

  always_ff @(negedge clk) begin
    hist <= {hist[FRAME_BITS-3:0], sdata};
  end

  // Includes the bit being sampled at this edge as the LSB.
  assign frame = {hist, sdata};

endmodule

// File: rtl/tdm_rx_unpack.sv
// Splits a captured frame into fields and holds them until the next commit.
module tdm_rx_unpack #(
  parameter int unsigned TAG_BITS  = 16,
  parameter int unsigned SLOT_BITS = 20,
  parameter int unsigned NUM_SLOTS = 12
) (
  input  logic                                                  clk,
  input  logic                                                  rst,
  input  logic                                                  commit,
  input  logic [tdm_rx_pkg::frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS)-1:0] frame,
  output logic [NUM_SLOTS*SLOT_BITS-1:0]                        slot_data,
  output logic [NUM_SLOTS-1:0]                                  slot_valid,
  output logic                                                  codec_ready,
  output logic                                                  gpio_irq,
  output logic                                                  frame_stb
);

  localparam int unsigned FRAME_BITS = tdm_rx_pkg::frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS);
  localparam int unsigned PAD_BITS   = TAG_BITS - NUM_SLOTS - 1;

  logic [NUM_SLOTS*SLOT_BITS-1:0] words_n;
  logic [NUM_SLOTS-1:0]           valid_n;

  // Frame position Fn sits at frame[FRAME_BITS-1-n].
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam int unsigned MSB = FRAME_BITS - 1 - TAG_BITS - SLOT_BITS * k;
    assign words_n[k*SLOT_BITS +: SLOT_BITS] = frame[MSB -: SLOT_BITS];
    assign valid_n[k] = frame[FRAME_BITS-2-k];
  end

  if (PAD_BITS > 0) begin : g_pad
    logic unused_tag_pad;
    assign unused_tag_pad = ^frame[FRAME_BITS-2-NUM_SLOTS -: PAD_BITS];
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      slot_data   <= '0;
      slot_valid  <= '0;
      codec_ready <= 1'b0;
      gpio_irq    <= 1'b0;
      frame_stb   <= 1'b0;
    end else begin
      frame_stb <= commit;
      if (commit) begin
        slot_data   <= words_n;
        slot_valid  <= valid_n;
        codec_ready <= frame[FRAME_BITS-1];
        gpio_irq    <= frame[0];
      end
    end
  end

endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx #(
  parameter int unsigned TAG_BITS  = tdm_rx_pkg::TAG_W_DEF,
  parameter int unsigned SLOT_BITS = tdm_rx_pkg::SLOT_W_DEF,
  parameter int unsigned NUM_SLOTS = tdm_rx_pkg::N_SLOTS_DEF
) (
  input  logic                           bit_clk,
  input  logic                           rst,
  input  logic                           sync,
  input  logic                           sdata,
  output logic [NUM_SLOTS*SLOT_BITS-1:0] slot_data,
  output logic [NUM_SLOTS-1:0]           slot_valid,
  output logic                           codec_ready,
  output logic                           gpio_irq,
  output logic                           frame_stb,
  output logic                           frame_err
);

  localparam int unsigned FRAME_BITS = tdm_rx_pkg::frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS);

  logic                  last_bit;
  logic [FRAME_BITS-1:0] frame;

  tdm_rx_framer #(
    .FRAME_BITS (FRAME_BITS)
  ) u_framer (
    .clk       (bit_clk),
    .rst       (rst),
    .sync      (sync),
    .last_bit  (last_bit),
    .frame_err (frame_err)
  );

  tdm_rx_deser #(
    .FRAME_BITS (FRAME_BITS)
  ) u_deser (
    .clk   (bit_clk),
    .sdata (sdata),
    .frame (frame)
  );

  tdm_rx_unpack #(
    .TAG_BITS  (TAG_BITS),
    .SLOT_BITS (SLOT_BITS),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_unpack (
    .clk         (bit_clk),
    .rst         (rst),
    .commit      (last_bit),
    .frame       (frame),
    .slot_data   (slot_data),
    .slot_valid  (slot_valid),
    .codec_ready (codec_ready),
    .gpio_irq    (gpio_irq),
    .frame_stb   (frame_stb)
  );

endmodule

// File: rtl/tdm_frame_rx_chk.sv
module tdm_frame_rx_chk #(
  parameter int unsigned TAG_BITS  = 16,
  parameter int unsigned SLOT_BITS = 20,
  parameter int unsigned NUM_SLOTS = 12
) (
  input logic                           bit_clk,
  input logic                           rst,
  input logic                           sync,
  input logic [NUM_SLOTS*SLOT_BITS-1:0] slot_data,
  input logic [NUM_SLOTS-1:0]           slot_valid,
  input logic                           codec_ready,
  input logic                           gpio_irq,
  input logic                           frame_stb,
  input logic                           frame_err
);

  localparam int unsigned FRAME_BITS = tdm_rx_pkg::frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS);
  localparam int unsigned GAP_W      = $clog2(FRAME_BITS + 1);

  // Cycles since the previous strobe, saturating at one frame.
  logic [GAP_W-1:0] gap;
  logic             seen_stb;

  always_ff @(negedge bit_clk) begin
    if (rst) begin
      gap      <= '0;
      seen_stb <= 1'b0;
    end else if (frame_stb) begin
      gap      <= GAP_W'(1);
      seen_stb <= 1'b1;
    end else if (gap < GAP_W'(FRAME_BITS)) begin
      gap <= gap + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(negedge bit_clk) disable iff (rst)
    $past(rst) |-> (slot_data == '0 && slot_valid == '0 && !codec_ready &&
                    !gpio_irq && !frame_stb && !frame_err));

  assert_stb_single_R7: assert property (@(negedge bit_clk) disable iff (rst)
    frame_stb |=> !frame_stb);

  assert_hold_between_R7: assert property (@(negedge bit_clk) disable iff (rst)
    !frame_stb |-> ($stable(slot_data) && $stable(slot_valid) &&
                    $stable(codec_ready) && $stable(gpio_irq)));

  assert_err_on_edge_R8: assert property (@(negedge bit_clk) disable iff (rst)
    frame_err |-> ($past(sync, 1) && !$past(sync, 2)));

  assert_err_no_stb_R8: assert property (@(negedge bit_clk) disable iff (rst)
    !(frame_err && frame_stb));

  assert_stb_spacing_R9: assert property (@(negedge bit_clk) disable iff (rst)
    frame_stb |-> (!seen_stb || gap >= GAP_W'(FRAME_BITS)));

endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(
  .TAG_BITS  (TAG_BITS),
  .SLOT_BITS (SLOT_BITS),
  .NUM_SLOTS (NUM_SLOTS)
) u_chk (
  .bit_clk     (bit_clk),
  .rst         (rst),
  .sync        (sync),
  .slot_data   (slot_data),
  .slot_valid  (slot_valid),
  .codec_ready (codec_ready),
  .gpio_irq    (gpio_irq),
  .frame_stb   (frame_stb),
  .frame_err   (frame_err)
);

// File: tb/tdm_frame_rx_bench.sv
module tdm_frame_rx_bench;

  localparam int TAGW = 16;
  localparam int SLW  = 20;
  localparam int NS   = 12;
  localparam int FB   = TAGW + SLW * NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync = 1'b0;
  logic sd = 1'b0;

  logic [NS*SLW-1:0] slot_data;
  logic [NS-1:0]     slot_valid;
  logic              codec_ready, gpio_irq, frame_stb, frame_err;

  always #2 clk = ~clk;  // 4 ns period

  tdm_frame_rx #(.TAG_BITS(TAGW), .SLOT_BITS(SLW), .NUM_SLOTS(NS)) u_tdm_frame_rx (
    .bit_clk     (clk),
    .rst         (rst),
    .sync        (sync),
    .sdata       (sd),
    .slot_data   (slot_data),
    .slot_valid  (slot_valid),
    .codec_ready (codec_ready),
    .gpio_irq    (gpio_irq),
    .frame_stb   (frame_stb),
    .frame_err   (frame_err)
  );

  int tests = 0;
  int fails = 0;
  int stb_seen = 0;
  int err_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_pos = 0;
  bit  m_locked = 0, m_prev = 0, m_armed = 0;
  bit  q[$];
  logic [NS*SLW-1:0] e_data;
  logic [NS-1:0]     e_valid;
  logic e_ready, e_irq, e_stb, e_err;

  always @(negedge clk) begin
    if (rst) begin
      e_data = '0; e_valid = '0; e_ready = 0; e_irq = 0; e_stb = 0; e_err = 0;
      m_pos = 0; m_locked = 0; m_prev = 0; q.delete(); m_armed = 1;
    end else begin
      bit rise;
      rise  = sync && !m_prev;
      e_stb = 0;
      e_err = 0;
      if (m_locked) q.push_back(sd);
      if (m_locked && m_pos == FB - 1) begin
        e_stb   = 1;
        e_ready = q[0];
        for (int s = 1; s <= NS; s++) e_valid[s-1] = q[s];
        for (int k = 0; k < NS; k++)
          for (int j = 0; j < SLW; j++)
            e_data[k*SLW + SLW-1-j] = q[TAGW + SLW*k + j];
        e_irq = q[FB-1];
        q.delete();
      end
      if (rise) begin
        if (m_locked && m_pos != FB - 1) e_err = 1;
        q.delete();
        m_pos = 0;
        m_locked = 1;
      end else if (m_locked) begin
        m_pos = (m_pos + 1) % FB;
      end
      m_prev = sync;
    end
  end

  // Compare every cycle, half a bit after the design's update edge.
  always @(posedge clk) begin
    if (m_armed && !done) begin
      chk(slot_data === e_data,    "R5 model slot_data",   slot_data, e_data);
      chk(slot_valid === e_valid,  "R4 model slot_valid",  slot_valid, e_valid);
      chk(codec_ready === e_ready, "R3 model codec_ready", codec_ready, e_ready);
      chk(gpio_irq === e_irq,      "R6 model gpio_irq",    gpio_irq, e_irq);
      chk(frame_stb === e_stb,     "R7 model frame_stb",   frame_stb, e_stb);
      chk(frame_err === e_err,     "R8 model frame_err",   frame_err, e_err);
      if (frame_stb) stb_seen++;
      if (frame_err) err_seen++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_bit(input logic s, input logic d);
    @(posedge clk);
    sync <= s;
    sd   <= d;
  endtask

  // f[i] is frame position Fi. Sync is high for the first 'hold' bits and,
  // if 'raise' is set, again on the last bit sent.
  task automatic send_frame(input logic [FB-1:0] f, input int len,
                            input int hold, input bit raise);
    for (int i = 0; i < len; i++)
      drive_bit((i < hold) || (raise && i == len - 1), f[i]);
  endtask

  function automatic logic [FB-1:0] make_frame(input bit rdy, input logic [NS-1:0] vld);
    logic [FB-1:0] f;
    for (int i = 0; i < FB; i += 32) f[i +: 32] = $urandom;
    f[0] = rdy;
    for (int s = 1; s <= NS; s++) f[s] = vld[s-1];
    for (int i = NS + 1; i < TAGW; i++) f[i] = 1'b0;
    return f;
  endfunction

  // Checks the outputs directly against the driven frame once F255 was taken.
  task automatic expect_frame(input logic [FB-1:0] f, input string tag);
    logic [NS*SLW-1:0] w;
    logic [NS-1:0]     v;
    @(negedge clk);
    #1;
    for (int k = 0; k < NS; k++)
      for (int j = 0; j < SLW; j++)
        w[k*SLW + SLW-1-j] = f[TAGW + SLW*k + j];
    for (int s = 0; s < NS; s++) v[s] = f[s+1];
    chk(codec_ready === f[0],  {tag, " R3 codec_ready"}, codec_ready, f[0]);
    chk(slot_valid === v,      {tag, " R4 slot_valid"},  slot_valid, v);
    chk(slot_data === w,       {tag, " R5 slot_data"},   slot_data, w);
    chk(gpio_irq === f[FB-1],  {tag, " R6 gpio_irq"},    gpio_irq, f[FB-1]);
    chk(frame_stb === 1'b1,    {tag, " R7 frame_stb"},   frame_stb, 1'b1);
  endtask

  task automatic expect_zero(input string tag);
    chk(slot_data === '0 && slot_valid === '0, {tag, " R1 words/flags"},
        {slot_valid, slot_data}, '0);
    chk(!codec_ready && !gpio_irq && !frame_stb && !frame_err, {tag, " R1 status"},
        {codec_ready, gpio_irq, frame_stb, frame_err}, '0);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    logic [FB-1:0] fa, fb, fc, fd, fe, ff, fg, fh, fi, fj, fk, fl, fm;
    int e0;

    repeat (5) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk); #1;
    expect_zero("after reset");

    // Data before any sync must be dropped (R2): send noise, then lock.
    send_frame(make_frame(1, '1), 30, 0, 0);
    @(negedge clk); #1;
    chk(frame_stb === 1'b0 && slot_data === '0, "R2 no output before sync",
        {frame_stb, slot_data}, '0);
    drive_bit(1'b1, 1'b1);

    // Normal chained frames with distinct tag patterns.
    e0 = err_seen;
    fa = make_frame(1, 12'hFFF); send_frame(fa, FB, 15, 1); expect_frame(fa, "R2 first frame");
    fb = make_frame(0, 12'h5A3); send_frame(fb, FB, 15, 1); expect_frame(fb, "R2 second frame");
    fc = make_frame(1, 12'h000); send_frame(fc, FB, 15, 1); expect_frame(fc, "R7 third frame");
    chk(err_seen - e0 == 0, "R7 no error on aligned frames", err_seen - e0, 0);

    // Early sync cuts a frame at bit 99.
    e0 = err_seen;
    fd = make_frame(1, 12'hFFF); send_frame(fd, 100, 15, 1);
    fe = make_frame(1, 12'hC31); send_frame(fe, FB, 15, 1); expect_frame(fe, "R8 resync");
    chk(err_seen - e0 == 1, "R8 one framing error", err_seen - e0, 1);

    // Missing sync: counter runs on; a late sync then errors.
    e0 = err_seen;
    ff = make_frame(0, 12'h0F0); send_frame(ff, FB, 15, 0); expect_frame(ff, "R9 no sync at end");
    fg = make_frame(1, 12'h801); send_frame(fg, FB, 0, 0);  expect_frame(fg, "R9 freewheel frame");
    fh = make_frame(1, 12'h3C3); send_frame(fh, 40, 0, 1);
    fi = make_frame(0, 12'hAAA); send_frame(fi, FB, 15, 1); expect_frame(fi, "R9 after late sync");
    chk(err_seen - e0 == 1, "R9 late sync flagged", err_seen - e0, 1);

    // Long sync pulses.
    e0 = err_seen;
    fj = make_frame(1, 12'h555); send_frame(fj, FB, 60, 1);  expect_frame(fj, "R10 sync 61 bits");
    fk = make_frame(0, 12'h00F); send_frame(fk, FB, 200, 1); expect_frame(fk, "R10 sync 201 bits");
    chk(err_seen - e0 == 0, "R10 long sync no error", err_seen - e0, 0);

    // Reset in the middle of a frame, then relock.
    fl = make_frame(1, 12'hFFF); send_frame(fl, 120, 15, 0);
    @(posedge clk); rst <= 1'b1;
    repeat (2) @(posedge clk); rst <= 1'b0;
    @(negedge clk); #1;
    expect_zero("mid-frame reset");
    drive_bit(1'b1, 1'b0);
    fm = make_frame(1, 12'h7E1); send_frame(fm, FB, 15, 1); expect_frame(fm, "R1 relock");

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(stb_seen == 10, "R7 total strobes", stb_seen, 10);
    chk(frame_stb === 1'b0, "R7 strobe is one cycle", frame_stb, 1'b0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule